// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a combinational datapath slice that takes two operands of parameterized width and produces one result with four status flags. A four-bit operation select and a carry input choose the operation. The top two select bits pick the unit: arithmetic, bitwise logic, shift right or shift left. In arithmetic mode the low two select bits choose what the ripple adder adds to operand A. That second input is B, the complement of B, all zeros or all ones. The carry input then picks between the two results of each pair.

The adder is a ripple chain built one bit at a time, with a small per-bit multiplexer in front of each stage. The carry flag comes from the carry out of the top stage. The overflow flag is the XOR of the carries into and out of the top stage. Each shift direction has its own serial input, which fills the bit position that the shift leaves empty. The block holds no state. It is meant to sit between the operand registers and the result register of a small processor datapath.

Top module: `alu_shift_slice`

## Requirements
- R1: With sel = 4'b0000 the result is (A + B + carry_in) modulo 2^W.
- R2: With sel = 4'b0001 the result is (A + ~B + carry_in) modulo 2^W, so carry_in = 1 gives A − B.
- R3: With sel = 4'b0010 the result is A + carry_in, which is a transfer when carry_in = 0 and an increment when carry_in = 1.
- R4: With sel = 4'b0011 the result is A plus all ones plus carry_in, which is a decrement when carry_in = 0 and a transfer when carry_in = 1.
- R5: With sel[3:2] = 2'b01, carry_in has no effect and sel[1:0] picks a bitwise operation: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, 11 gives NOT A.
- R6: With sel[3:2] = 2'b10 the result is A shifted right by one place, with ser_right_in entering the MSB. sel[1:0] and carry_in have no effect.
- R7: With sel[3:2] = 2'b11 the result is A shifted left by one place, with ser_left_in entering the LSB. sel[1:0] and carry_in have no effect.
- R8: In arithmetic mode flag_c equals the carry out of the MSB stage, which is bit W of the unbounded sum.
- R9: In arithmetic mode flag_v is high exactly when both adder inputs have the same sign and the result's sign differs from it.
- R10: In every mode flag_s equals res[W-1], and flag_z is high exactly when every bit of res is 0.
- R11: In logic and shift modes flag_c and flag_v are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand, and the operand that the shifts move |
| op_b | input | W | Second operand |
| carry_in | input | 1 | Carry into the LSB adder stage |
| sel | input | 4 | Operation select: [3:2] picks the unit, [1:0] picks the operation within it |
| ser_right_in | input | 1 | Bit that fills the MSB on a right shift |
| ser_left_in | input | 1 | Bit that fills the LSB on a left shift |
| res | output | W | Result |
| flag_c | output | 1 | Carry out of the MSB stage (arithmetic only) |
| flag_v | output | 1 | Signed overflow (arithmetic only) |
| flag_s | output | 1 | Sign, which is the MSB of the result |
| flag_z | output | 1 | High when the result is zero |

## Verification
The hardest case to reach is a carry into the MSB stage that differs from the carry out of it. That is the only way to set the overflow flag, and random operands seldom produce it together with the right select. The stimulus therefore pairs zero, all ones and the most negative value with each other under all sixteen select and carry-in combinations. Those pairs put signed overflow into the add and subtract codes and a full carry chain into the increment and decrement codes. Random operands with random serial inputs then cover the middle of the range, and every combination is compared with a model written in integer arithmetic.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

    typedef enum logic [1:0] {
        UNIT_ARITH = 2'b00,
        UNIT_LOGIC = 2'b01,
        UNIT_SHR   = 2'b10,
        UNIT_SHL   = 2'b11
    } unit_e;

    typedef enum logic [1:0] {
        ADDIN_B    = 2'b00,
        ADDIN_NOTB = 2'b01,
        ADDIN_ZERO = 2'b10,
        ADDIN_ONES = 2'b11
    } addin_e;

    typedef enum logic [1:0] {
        LOP_AND  = 2'b00,
        LOP_OR   = 2'b01,
        LOP_XOR  = 2'b10,
        LOP_NOTA = 2'b11
    } lop_e;

    typedef struct packed {
        logic c;
        logic v;
        logic s;
        logic z;
    } flags_t;

    // Second adder input for one bit position
    function automatic logic addin_bit(input addin_e pick, input logic b);
        case (pick)
            ADDIN_B:    return b;
            ADDIN_NOTB: return ~b;
            ADDIN_ZERO: return 1'b0;
            default:    return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
    import alsu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  addin_e       pick,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         c_into_msb
);
    logic [W:0]   carry;
    logic [W-1:0] y;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign y[i]       = addin_bit(pick, b[i]);
        assign sum[i]     = a[i] ^ y[i] ^ carry[i];
        assign carry[i+1] = (a[i] & y[i]) | (carry[i] & (a[i] ^ y[i]));
    end

    assign cout       = carry[W];
    assign c_into_msb = carry[W-1];
endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
    import alsu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  lop_e         op,
    output logic [W-1:0] out
);
    always_comb begin
        case (op)
            LOP_AND: out = a & b;
            LOP_OR:  out = a | b;
            LOP_XOR: out = a ^ b;
            default: out = ~a;
        endcase
    end
endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
    parameter int W    = 8,
    parameter bit LEFT = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic         fill,
    output logic [W-1:0] out
);
    if (LEFT) begin : g_left
        assign out = {a[W-2:0], fill};
    end else begin : g_right
        assign out = {fill, a[W-1:1]};
    end
endmodule

// File: rtl/alu_shift_slice.sv
module alu_shift_slice
    import alsu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    input  logic [3:0]   sel,
    input  logic         ser_right_in,
    input  logic         ser_left_in,
    output logic [W-1:0] res,
    output logic         flag_c,
    output logic         flag_v,
    output logic         flag_s,
    output logic         flag_z
);
    unit_e        unit;
    logic [W-1:0] arith_out, logic_out, shr_out, shl_out;
    logic         arith_cout, arith_cmsb;
    flags_t       flg;

    assign unit = unit_e'(sel[3:2]);

    alsu_arith #(.W(W)) u_arith (
        .a          (op_a),
        .b          (op_b),
        .pick       (addin_e'(sel[1:0])),
        .cin        (carry_in),
        .sum        (arith_out),
        .cout       (arith_cout),
        .c_into_msb (arith_cmsb)
    );

    alsu_logic #(.W(W)) u_logic (
        .a   (op_a),
        .b   (op_b),
        .op  (lop_e'(sel[1:0])),
        .out (logic_out)
    );

    alsu_shift #(.W(W), .LEFT(1'b0)) u_shr (
        .a    (op_a),
        .fill (ser_right_in),
        .out  (shr_out)
    );

    alsu_shift #(.W(W), .LEFT(1'b1)) u_shl (
        .a    (op_a),
        .fill (ser_left_in),
        .out  (shl_out)
    );

    always_comb begin
        case (unit)
            UNIT_ARITH: res = arith_out;
            UNIT_LOGIC: res = logic_out;
            UNIT_SHR:   res = shr_out;
            default:    res = shl_out;
        endcase
    end

    always_comb begin
        flg.c = (unit == UNIT_ARITH) & arith_cout;
        flg.v = (unit == UNIT_ARITH) & (arith_cout ^ arith_cmsb);
        flg.s = res[W-1];
        flg.z = ~|res;
    end

    assign flag_c = flg.c;
    assign flag_v = flg.v;
    assign flag_s = flg.s;
    assign flag_z = flg.z;
endmodule

// File: rtl/alu_shift_slice_chk.sv
module alu_shift_slice_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         carry_in,
    input logic [3:0]   sel,
    input logic         ser_right_in,
    input logic         ser_left_in,
    input logic [W-1:0] res,
    input logic         flag_c,
    input logic         flag_v,
    input logic         flag_s,
    input logic         flag_z
);
    logic [W-1:0] addend;
    logic [W:0]   wide;

    always_comb begin
        case (sel[1:0])
            2'b00:   addend = op_b;
            2'b01:   addend = ~op_b;
            2'b10:   addend = '0;
            default: addend = '1;
        endcase
        wide = {1'b0, op_a} + {1'b0, addend} + {{W{1'b0}}, carry_in};
    end

    always_comb begin
        if (sel[3:2] == 2'b00) begin
            // R8
            carry_out_chk: assert (flag_c == wide[W])
                else $error("carry flag does not match sum bit W");
            // R9
            signed_ovf_chk: assert (flag_v ==
                ((op_a[W-1] == addend[W-1]) && (res[W-1] != op_a[W-1])))
                else $error("overflow flag does not match sign rule");
        end else begin
            // R11
            flags_quiet_chk: assert (!flag_c && !flag_v)
                else $error("carry or overflow set outside arithmetic");
        end
        // R10
        sign_zero_chk: assert ((flag_s == res[W-1]) && (flag_z == (res == '0)))
            else $error("sign or zero flag inconsistent with result");
        if (sel[3:2] == 2'b10) begin
            // R6
            shr_fill_chk: assert (res == {ser_right_in, op_a[W-1:1]})
                else $error("right shift result wrong");
        end
        if (sel[3:2] == 2'b11) begin
            // R7
            shl_fill_chk: assert (res == {op_a[W-2:0], ser_left_in})
                else $error("left shift result wrong");
        end
    end
endmodule

bind alu_shift_slice alu_shift_slice_chk #(.W(W)) u_chk (
    .op_a         (op_a),
    .op_b         (op_b),
    .carry_in     (carry_in),
    .sel          (sel),
    .ser_right_in (ser_right_in),
    .ser_left_in  (ser_left_in),
    .res          (res),
    .flag_c       (flag_c),
    .flag_v       (flag_v),
    .flag_s       (flag_s),
    .flag_z       (flag_z)
);

// File: tb/alu_shift_slice_test.sv
module alu_shift_slice_test;
    localparam int W = 8;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         carry_in = 1'b0;
    logic [3:0]   sel = 4'h0;
    logic         ser_right_in = 1'b0, ser_left_in = 1'b0;
    logic [W-1:0] res;
    logic         flag_c, flag_v, flag_s, flag_z;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alu_shift_slice #(.W(W)) uut (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .sel(sel),
        .ser_right_in(ser_right_in), .ser_left_in(ser_left_in),
        .res(res), .flag_c(flag_c), .flag_v(flag_v),
        .flag_s(flag_s), .flag_z(flag_z)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s sel=%b cin=%b a=%h b=%h: actual %0h expected %0h",
                     tag, sel, carry_in, op_a, op_b, act, exp);
        end
    endtask

    // Behavioural model in integers, then compare every output
    task automatic run_one(input int a, input int b, input bit cin,
                           input int s, input bit sr, input bit sl);
        int e_res, e_c, e_v, y, total;
        string rtag;
        @(negedge clk);
        op_a = W'(a); op_b = W'(b); carry_in = cin; sel = 4'(s);
        ser_right_in = sr; ser_left_in = sl;
        e_c = 0; e_v = 0;
        case (s >> 2)
            0: begin
                case (s & 3)
                    0: begin y = b;          rtag = "R1"; end
                    1: begin y = ~b & MASK;  rtag = "R2"; end
                    2: begin y = 0;          rtag = "R3"; end
                    default: begin y = MASK; rtag = "R4"; end
                endcase
                total = a + y + int'(cin);
                e_res = total & MASK;
                e_c = (total >> W) & 1;
                e_v = (((a >> (W-1)) & 1) == ((y >> (W-1)) & 1) &&
                       ((e_res >> (W-1)) & 1) != ((a >> (W-1)) & 1)) ? 1 : 0;
            end
            1: begin
                rtag = "R5";
                case (s & 3)
                    0: e_res = a & b;
                    1: e_res = a | b;
                    2: e_res = a ^ b;
                    default: e_res = ~a & MASK;
                endcase
            end
            2: begin rtag = "R6"; e_res = (a >> 1) | (int'(sr) << (W-1)); end
            default: begin rtag = "R7"; e_res = ((a << 1) & MASK) | int'(sl); end
        endcase
        #2;
        check(rtag, int'(res), e_res);
        if ((s >> 2) == 0) begin
            check("R8", int'(flag_c), e_c);
            check("R9", int'(flag_v), e_v);
        end else begin
            // R11: quiet flags outside arithmetic
            check("R11", int'({flag_c, flag_v}), 0);
        end
        // R10
        check("R10", int'({flag_s, flag_z}),
              (((e_res >> (W-1)) & 1) << 1) | (e_res == 0 ? 1 : 0));
    endtask

    initial begin
        int corner[3];
        corner[0] = 0; corner[1] = MASK; corner[2] = 1 << (W-1);
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        // Reset state with all inputs low: zero result, zero flag only (R10, R1)
        check("R1", int'(res), 0);
        check("R10", int'({flag_c, flag_v, flag_s, flag_z}), 1);
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 2; c++) begin
                for (int i = 0; i < 3; i++)
                    for (int j = 0; j < 3; j++)
                        run_one(corner[i], corner[j], c[0], s, 1'b1, 1'b1);
                run_one(1, 1, c[0], s, 1'b0, 1'b0);
                run_one(MASK >> 1, 1, c[0], s, 1'b0, 1'b1);
                for (int r = 0; r < 20; r++)
                    run_one(int'($urandom) & MASK, int'($urandom) & MASK, c[0], s,
                            1'($urandom), 1'($urandom));
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule